// File: doc/BRIEF.md
# Polled Console Byte Port

A memory-mapped console endpoint that moves single characters between software and two byte streams. Software on the register bus polls a receive status register; while that register is zero, each status read asks the receive stream for a byte. If one is offered, it is taken into the receive holding register and the status becomes 1. If none is offered, both the holding register and the status are cleared. Once the status is nonzero, the status read returns the held value and does not poll. Software consumes the byte and writes the status back to zero to arm the next poll.

On the transmit side, a write to the transmit data register keeps a readable copy of the byte, sets the transmit status to 1 (ready) and presents the byte on the outgoing stream until the sink accepts it. All four registers can also be written directly by software. Registers are 8 bits wide. A read places the register value in the low byte of the read data and returns zeros in the upper bytes.

Register offsets on the 6-bit bus address: receive data 0x10, receive status 0x14, transmit data 0x18, transmit status 0x1a. Any other offset reads as zero and ignores writes.

Top module: `console_byte_port`

## Requirements
- R1: After a synchronous active-low reset, receive data and receive status read 0, transmit data reads 0, transmit status reads 1, and tx_valid and rx_ready are low.
- R2: A read of receive status (0x14) while it holds zero asserts rx_ready in that same cycle. If rx_valid is high, the read returns 1, and afterwards receive data holds rx_data and receive status holds 1.
- R3: A read of receive status while it holds zero, with rx_valid low, returns 0 and clears receive data and receive status to 0.
- R4: A read of receive status while it holds a nonzero value returns that value, keeps rx_ready low and leaves receive data unchanged.
- R5: A read of receive data (0x10) returns the held byte, keeps rx_ready low and leaves receive status unchanged.
- R6: Bus writes to receive data (0x10), receive status (0x14) and transmit status (0x1a) replace the register with bus_wdata, which reads back afterwards.
- R7: A write to transmit data (0x18) stores the byte for readback and sets transmit status to 1. From the next cycle it raises tx_valid with tx_data equal to the byte.
- R8: tx_valid stays high with stable tx_data until tx_ready is seen, and falls in the cycle after that handshake.
- R9: A transmit data write while a byte is still pending replaces tx_data, and tx_valid stays high.
- R10: bus_rdata bits above 7 are always zero, and a read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | BUS_W (32) | Read data, register value in bits 7:0 |
| rx_valid | input | 1 | Receive stream offers a byte |
| rx_data | input | 8 | Offered receive byte |
| rx_ready | output | 1 | Receive byte taken this cycle (poll) |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink accepts the transmit byte |

## Verification
If the receive status is wrong, the next status read shows it right away. A status stuck nonzero returns a stale value and never raises rx_ready. A status stuck at zero polls again and overwrites a byte that software has not yet consumed. If the holding register is wrong, the next data read shows it. A wrong transmit pending flag shows up on tx_valid in the first cycle after a write or handshake, either as a dropped byte or as a byte sent twice. Each of these faults is visible within one or two bus accesses of the stimulus that exposes it.

// File: rtl/console_pkg.sv
// Package: shared constants and register select type for the console port.
// Assumes 8-bit registers and offsets that fit in the bus address width.
package console_pkg;
    localparam int unsigned REG_W        = 8;
    localparam int unsigned OFS_IN_DATA  = 'h10;
    localparam int unsigned OFS_IN_STAT  = 'h14;
    localparam int unsigned OFS_OUT_DATA = 'h18;
    localparam int unsigned OFS_OUT_STAT = 'h1a;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IN_DATA,
        SEL_IN_STAT,
        SEL_OUT_DATA,
        SEL_OUT_STAT
    } reg_sel_e;
endpackage

// File: rtl/console_addr_decode.sv
// Module: maps a bus offset onto one of the four console registers.
// Assumes ADDR_W is wide enough to hold the largest offset (0x1a).
module console_addr_decode
    import console_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Purpose: compare the offset against each register location.
    always_comb begin
        if (addr == ADDR_W'(OFS_IN_DATA))       sel = SEL_IN_DATA;
        else if (addr == ADDR_W'(OFS_IN_STAT))  sel = SEL_IN_STAT;
        else if (addr == ADDR_W'(OFS_OUT_DATA)) sel = SEL_OUT_DATA;
        else if (addr == ADDR_W'(OFS_OUT_STAT)) sel = SEL_OUT_STAT;
        else                                    sel = SEL_NONE;
    end
endmodule

// File: rtl/console_rx_hold.sv
// Module: receive holding register and status. A status read while the
// status is zero polls the receive stream. It captures an offered byte,
// or clears both registers when nothing is offered.
// Assumes a status read and a register write never coincide.
module console_rx_hold
    import console_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_rd,
    input  logic             data_wr,
    input  logic             stat_wr,
    input  logic [REG_W-1:0] wbyte,
    input  logic             rx_valid,
    input  logic [REG_W-1:0] rx_data,
    output logic             rx_ready,
    output logic [REG_W-1:0] hold_data,
    output logic [REG_W-1:0] hold_stat,
    output logic [REG_W-1:0] stat_view
);
    logic poll;

    // Purpose: poll only when the status is empty.
    always_comb begin
        poll     = stat_rd && (hold_stat == '0);
        rx_ready = poll;
    end

    // Purpose: value returned by a status read, after any poll.
    always_comb begin
        if (hold_stat != '0) stat_view = hold_stat;
        else if (rx_valid)   stat_view = REG_W'(1);
        else                 stat_view = '0;
    end

    // Purpose: update the holding registers from a poll or a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_stat <= '0;
        end else if (poll) begin
            hold_data <= rx_valid ? rx_data : '0;
            hold_stat <= rx_valid ? REG_W'(1) : '0;
        end else begin
            if (data_wr) hold_data <= wbyte;
            if (stat_wr) hold_stat <= wbyte;
        end
    end
endmodule

// File: rtl/console_tx_hold.sv
// Module: transmit data copy, transmit status and outgoing stream.
// A data write stores the byte, sets status to ready and marks it pending
// until the sink accepts it. A write while pending replaces the byte.
module console_tx_hold
    import console_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic             stat_wr,
    input  logic [REG_W-1:0] wbyte,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [REG_W-1:0] tx_data,
    output logic [REG_W-1:0] out_data,
    output logic [REG_W-1:0] out_stat
);
    logic pending;

    // Purpose: drive the stream from the stored copy.
    always_comb begin
        tx_valid = pending;
        tx_data  = out_data;
    end

    // Purpose: store the byte and its status on software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_stat <= REG_W'(1);
        end else if (data_wr) begin
            out_data <= wbyte;
            out_stat <= REG_W'(1);
        end else if (stat_wr) begin
            out_stat <= wbyte;
        end
    end

    // Purpose: track whether the sink still has to accept a byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pending <= 1'b0;
        else if (data_wr)              pending <= 1'b1;
        else if (pending && tx_ready)  pending <= 1'b0;
    end
endmodule

// File: rtl/console_byte_port.sv
// Module: top of the polled console byte port. It decodes bus accesses,
// routes them to the receive and transmit holding logic and builds the
// read data with the register byte in the low lane.
// Assumes BUS_W is a multiple of 8 and at least 8.
module console_byte_port
    import console_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [REG_W-1:0]  rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [REG_W-1:0]  tx_data,
    input  logic              tx_ready
);
    localparam int unsigned PAD_W = BUS_W - REG_W;

    reg_sel_e         sel;
    logic             rd_en;
    logic             wr_en;
    logic [REG_W-1:0] in_data;
    logic [REG_W-1:0] in_stat;
    logic [REG_W-1:0] in_view;
    logic [REG_W-1:0] out_data;
    logic [REG_W-1:0] out_stat;
    logic [REG_W-1:0] rd_byte;

    console_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Purpose: split the strobe into read and write.
    always_comb begin
        rd_en = bus_en && !bus_wr;
        wr_en = bus_en && bus_wr;
    end

    console_rx_hold u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd   (rd_en && (sel == SEL_IN_STAT)),
        .data_wr   (wr_en && (sel == SEL_IN_DATA)),
        .stat_wr   (wr_en && (sel == SEL_IN_STAT)),
        .wbyte     (bus_wdata),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .hold_data (in_data),
        .hold_stat (in_stat),
        .stat_view (in_view)
    );

    console_tx_hold u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (wr_en && (sel == SEL_OUT_DATA)),
        .stat_wr  (wr_en && (sel == SEL_OUT_STAT)),
        .wbyte    (bus_wdata),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .out_data (out_data),
        .out_stat (out_stat)
    );

    // Purpose: select the register byte for a read.
    always_comb begin
        unique case (sel)
            SEL_IN_DATA:  rd_byte = in_data;
            SEL_IN_STAT:  rd_byte = in_view;
            SEL_OUT_DATA: rd_byte = out_data;
            SEL_OUT_STAT: rd_byte = out_stat;
            default:      rd_byte = '0;
        endcase
    end

    // Purpose: place the byte in the low lane, zero the rest.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb bus_rdata = {{PAD_W{1'b0}}, rd_byte};
        end else begin : g_nopad
            always_comb bus_rdata = rd_byte;
        end
    endgenerate
endmodule

// File: rtl/console_byte_port_chk.sv
// Module: assertion checker for the console byte port, bound to the top.
module console_byte_port_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BUS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              rx_valid,
    input logic [7:0]        rx_data,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic [7:0]        in_data,
    input logic [7:0]        in_stat
);
    logic wr_out;
    logic stat_rd;
    always_comb begin
        wr_out  = bus_en && bus_wr && (bus_addr == ADDR_W'('h18));
        stat_rd = bus_en && !bus_wr && (bus_addr == ADDR_W'('h14));
    end

    AST_RX_READY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> stat_rd && (in_stat == 8'd0)); // R2
    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && rx_valid |=> in_data == $past(rx_data) && in_stat == 8'd1); // R2
    AST_RX_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && !rx_valid |=> in_data == 8'd0 && in_stat == 8'd0); // R3
    AST_NO_POLL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && in_stat != 8'd0 |-> !rx_ready); // R4
    AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> tx_valid && tx_data == $past(bus_wdata)); // R7
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !wr_out |=> tx_valid && $stable(tx_data)); // R8
    AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && !wr_out |=> !tx_valid); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:8] == '0); // R10
endmodule

bind console_byte_port console_byte_port_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .in_data   (in_data),
    .in_stat   (in_stat)
);

// File: tb/test_console_byte_port.sv
// Bench: directed scenarios for the console byte port, one task each.
module test_console_byte_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd_val;
    logic        rd_rdy;

    always #2.5 clk = ~clk;

    console_byte_port i_console_byte_port (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus read: drive after negedge, sample comb outputs, finish at next negedge.
    task automatic bus_read(input logic [5:0] a);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        rd_val = bus_rdata;
        rd_rdy = rx_ready;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        check("R1 rx_ready", {31'd0, rx_ready}, 32'd0);
        bus_read(6'h10); check("R1 in data", rd_val, 32'd0);
        bus_read(6'h18); check("R1 out data", rd_val, 32'd0);
        bus_read(6'h1a); check("R1 out status", rd_val, 32'd1);
        // Status read with nothing offered must read 0.
        bus_read(6'h14); check("R1 in status", rd_val, 32'd0);
    endtask

    task automatic t_rx_capture();
        rx_valid = 1'b1; rx_data = 8'hA7;
        bus_read(6'h14);
        check("R2 status read", rd_val, 32'd1);
        check("R2 rx_ready", {31'd0, rd_rdy}, 32'd1);
        rx_valid = 1'b0;
        bus_read(6'h10);
        check("R2 captured data", rd_val, 32'hA7);
        check("R5 no rx_ready on data read", {31'd0, rd_rdy}, 32'd0);
        bus_read(6'h14);
        check("R5 status kept after data read", rd_val, 32'd1);
    endtask

    task automatic t_no_poll_when_full();
        rx_valid = 1'b1; rx_data = 8'h3C;
        bus_read(6'h14);
        check("R4 status held", rd_val, 32'd1);
        check("R4 no rx_ready", {31'd0, rd_rdy}, 32'd0);
        rx_valid = 1'b0;
        bus_read(6'h10);
        check("R4 data unchanged", rd_val, 32'hA7);
    endtask

    task automatic t_overwrite_and_clear();
        bus_write(6'h14, 8'h00);
        bus_write(6'h10, 8'h55);
        bus_read(6'h10);
        check("R6 in data write", rd_val, 32'h55);
        bus_write(6'h14, 8'h9E);
        bus_read(6'h14);
        check("R6 in status write", rd_val, 32'h9E);
        bus_write(6'h14, 8'h00);
        bus_read(6'h14);
        check("R3 empty poll reads 0", rd_val, 32'd0);
        check("R3 poll asserted rx_ready", {31'd0, rd_rdy}, 32'd1);
        bus_read(6'h10);
        check("R3 data cleared", rd_val, 32'd0);
        // A new byte overwrites after software re-arms.
        rx_valid = 1'b1; rx_data = 8'h61;
        bus_read(6'h14);
        rx_valid = 1'b0;
        bus_read(6'h10);
        check("R2 second byte", rd_val, 32'h61);
    endtask

    task automatic t_tx_stream();
        bus_write(6'h1a, 8'h00);
        bus_read(6'h1a);
        check("R6 out status write", rd_val, 32'd0);
        tx_ready = 1'b0;
        bus_write(6'h18, 8'hC4);
        check("R7 tx_valid", {31'd0, tx_valid}, 32'd1);
        check("R7 tx_data", {24'd0, tx_data}, 32'hC4);
        bus_read(6'h18);
        check("R7 readback", rd_val, 32'hC4);
        bus_read(6'h1a);
        check("R7 status set", rd_val, 32'd1);
        repeat (3) @(negedge clk);
        check("R8 held", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'hC4});
        bus_write(6'h18, 8'h2B);
        check("R9 replaced", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'h2B});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        check("R8 dropped after handshake", {31'd0, tx_valid}, 32'd0);
    endtask

    task automatic t_lanes();
        bus_write(6'h1a, 8'hFF);
        bus_read(6'h1a);
        check("R10 low lane only", rd_val, 32'h0000_00FF);
        bus_write(6'h20, 8'h77);
        bus_read(6'h20);
        check("R10 unmapped", rd_val, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_capture();
        t_no_poll_when_full();
        t_overwrite_and_clear();
        t_tx_stream();
        t_lanes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule